// File: doc/BRIEF.md
# Thermal Fault Flag Controller

This block turns four digital temperature comparator outputs into two latched fault flags and a shutdown sequence for a pair of gate-driver sides. The comparators say whether the junction is above the warning-entry level, below the warning-exit level, above the shutdown-entry level and below the shutdown-exit level. Each comparator output must stay true for a run of consecutive clock cycles before the block acts on it. The length of that run is set through an input.

The warning flag only records the event. The shutdown flag turns the charge pump off and forces the low-side drivers into full-strength sink. The high side gets a two-phase switch-off. First it is actively sunk for a window counted in reference ticks. Then it is disabled, with only the passive gate-source path left. The window ends early whenever the charge-pump margin input drops.

A read-and-clear strobe from the register side removes a flag only when the matching exit condition has already been qualified. Otherwise the flag stays set. Clearing the shutdown flag returns every driver output to normal and releases the charge pump.

Top module: `thermal_fault_ctrl`

## Requirements
- R1: With a filter length of L, the warning flag reads 1 after the second clock edge that follows L+1 consecutive cycles of the warning-entry input high. It is still 0 one edge earlier.
- R2: A set warning flag leaves the driver mode outputs and the charge-pump disable output unchanged.
- R3: A single cycle with a qualifying input low restarts its qualification count from zero.
- R4: The warning flag never clears by itself. A read-and-clear strobe clears it only when the warning-exit input has been high for at least L+1 consecutive cycles before the strobe edge. Otherwise the strobe leaves the flag set.
- R5: The shutdown flag follows the timing of R1 for the shutdown-entry input. The charge-pump disable output rises on the same edge as the flag.
- R6: The driver mode encoding is 00 normal, 01 forced sink and 10 disabled. The low-side mode reads 01 for as long as the shutdown flag is set, and 00 otherwise.
- R7: When shutdown sets while the margin input is high, the high-side mode reads 01 from the setting edge. It changes to 10 on the edge that samples the SINK_TICKS-th reference tick.
- R8: When the margin input is low while the high-side mode is 01, or at the edge where shutdown sets, the high-side mode reads 10 after that edge.
- R9: Low-side sink, high-side disable and charge-pump disable are held until the shutdown flag is cleared under the rule of R4, applied to the shutdown-exit input. On that edge all modes return to 00 and charge-pump disable returns to 0.
- R10: After reset both flags are 0, both modes are 00 and charge-pump disable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| filt_len_i | input | FILT_W | Qualification length L |
| warn_above_i | input | 1 | Temperature above the warning-entry level |
| warn_below_i | input | 1 | Temperature below the warning-exit level |
| sd_above_i | input | 1 | Temperature above the shutdown-entry level |
| sd_below_i | input | 1 | Temperature below the shutdown-exit level |
| rc_strobe_i | input | 1 | Read-and-clear request, one cycle |
| tick_i | input | 1 | Reference tick for the sink window |
| cp_margin_i | input | 1 | Charge-pump voltage has enough margin above the bridge supply |
| warn_flag_o | output | 1 | Latched warning flag |
| sd_flag_o | output | 1 | Latched shutdown flag |
| ls_mode_o | output | 2 | Low-side driver mode |
| hs_mode_o | output | 2 | High-side driver mode |
| cp_disable_o | output | 1 | Charge-pump disable request |

## Verification
The bench checks the exact edge on which each flag sets. A filter that is off by one would set a cycle early or late, and a filter that forgets to restart after a one-cycle dropout would set early on a glitchy input. Read-and-clear is tried both inside the hysteresis band and one edge before the exit condition qualifies. A clear rule that is too loose would drop the flag while the part is still hot. The high-side window is counted down to the last tick, and it is also cut short by the margin input, both mid-window and at entry. A wrong window count or an ignored margin would leave the high side sinking when it should be disabled.

// File: rtl/thermal_pkg.sv
package thermal_pkg;

    // Per-side gate driver mode, encoding fixed by the requirements
    typedef enum logic [1:0] {
        DRV_NORMAL = 2'b00,
        DRV_SINK   = 2'b01,
        DRV_OFF    = 2'b10
    } drv_mode_e;

    // Shutdown sequencer states
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'b00,
        SEQ_HS_SINK = 2'b01,
        SEQ_HS_OFF  = 2'b10
    } seq_state_e;

    // Comparator lanes: an entry and an exit condition per flag
    localparam int unsigned NUM_FLAGS = 2;
    localparam int unsigned NUM_COND  = 2 * NUM_FLAGS;
    localparam int unsigned WARN_IDX  = 0;
    localparam int unsigned SD_IDX    = 1;

    typedef struct packed {
        drv_mode_e ls;
        drv_mode_e hs;
        logic      cp_off;
    } drv_ctrl_t;

    // Set has priority; clear only removes a flag that is held
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    // Driver outputs are a pure function of the sequencer state
    function automatic drv_ctrl_t drv_from_state(input seq_state_e s);
        drv_ctrl_t d;
        case (s)
            SEQ_IDLE:    d = '{ls: DRV_NORMAL, hs: DRV_NORMAL, cp_off: 1'b0};
            SEQ_HS_SINK: d = '{ls: DRV_SINK,   hs: DRV_SINK,   cp_off: 1'b1};
            default:     d = '{ls: DRV_SINK,   hs: DRV_OFF,    cp_off: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/qual_filter.sv
module qual_filter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cond_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             qual_o
);

    logic [CNT_W-1:0] run_q;
    logic             qual_q;

    // Counts consecutive high samples; qualifies once the run exceeds len_i
    always_ff @(posedge clk_i) begin
        if (rst_i || !cond_i) begin
            run_q  <= '0;
            qual_q <= 1'b0;
        end else if (run_q >= len_i) begin
            qual_q <= 1'b1;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = qual_q;

endmodule

// File: rtl/fault_flag.sv
module fault_flag
    import thermal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) flag_q <= 1'b0;
        else       flag_q <= flag_next(flag_q, set_i, clr_i);
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
    import thermal_pkg::*;
#(
    parameter int unsigned SINK_TICKS = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      sd_set_i,
    input  logic      sd_clr_i,
    input  logic      tick_i,
    input  logic      margin_i,
    output drv_ctrl_t drv_o
);

    localparam int unsigned TW = $clog2(SINK_TICKS + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(SINK_TICKS - 1);

    seq_state_e    state_q;
    logic [TW-1:0] tick_cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= SEQ_IDLE;
            tick_cnt_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    tick_cnt_q <= '0;
                    if (sd_set_i) state_q <= margin_i ? SEQ_HS_SINK : SEQ_HS_OFF;
                end
                SEQ_HS_SINK: begin
                    if (sd_clr_i) begin
                        state_q <= SEQ_IDLE;
                    end else if (!margin_i) begin
                        state_q <= SEQ_HS_OFF;
                    end else if (tick_i) begin
                        if (tick_cnt_q == LAST_TICK) state_q <= SEQ_HS_OFF;
                        else                         tick_cnt_q <= tick_cnt_q + 1'b1;
                    end
                end
                SEQ_HS_OFF: begin
                    if (sd_clr_i) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign drv_o = drv_from_state(state_q);

endmodule

// File: rtl/thermal_fault_ctrl.sv
module thermal_fault_ctrl
    import thermal_pkg::*;
#(
    parameter int unsigned FILT_W     = 8,
    parameter int unsigned SINK_TICKS = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [FILT_W-1:0] filt_len_i,
    input  logic              warn_above_i,
    input  logic              warn_below_i,
    input  logic              sd_above_i,
    input  logic              sd_below_i,
    input  logic              rc_strobe_i,
    input  logic              tick_i,
    input  logic              cp_margin_i,
    output logic              warn_flag_o,
    output logic              sd_flag_o,
    output logic [1:0]        ls_mode_o,
    output logic [1:0]        hs_mode_o,
    output logic              cp_disable_o
);

    // Lane 2k is the entry condition of flag k, lane 2k+1 its exit condition
    logic [NUM_COND-1:0]  cond_vec;
    logic [NUM_COND-1:0]  qual_vec;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic                 sd_set_evt;
    logic                 sd_clr_evt;
    drv_ctrl_t            drv;

    assign cond_vec = {sd_below_i, sd_above_i, warn_below_i, warn_above_i};

    for (genvar i = 0; i < NUM_COND; i++) begin : g_filt
        qual_filter #(.CNT_W(FILT_W)) u_filt (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .cond_i (cond_vec[i]),
            .len_i  (filt_len_i),
            .qual_o (qual_vec[i])
        );
    end

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        assign flag_set[k] = qual_vec[2*k];
        assign flag_clr[k] = rc_strobe_i & qual_vec[2*k+1] & ~qual_vec[2*k];
        fault_flag u_flag (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .set_i  (flag_set[k]),
            .clr_i  (flag_clr[k]),
            .flag_o (flag_vec[k])
        );
    end

    // Sequencer steps on the same edge as the shutdown flag changes
    assign sd_set_evt = flag_set[SD_IDX] & ~flag_vec[SD_IDX];
    assign sd_clr_evt = flag_clr[SD_IDX] &  flag_vec[SD_IDX];

    hs_sequencer #(.SINK_TICKS(SINK_TICKS)) u_seq (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sd_set_i (sd_set_evt),
        .sd_clr_i (sd_clr_evt),
        .tick_i   (tick_i),
        .margin_i (cp_margin_i),
        .drv_o    (drv)
    );

    assign warn_flag_o  = flag_vec[WARN_IDX];
    assign sd_flag_o    = flag_vec[SD_IDX];
    assign ls_mode_o    = drv.ls;
    assign hs_mode_o    = drv.hs;
    assign cp_disable_o = drv.cp_off;

endmodule

// File: rtl/thermal_fault_chk.sv
module thermal_fault_chk
    import thermal_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       warn_above_i,
    input logic       sd_above_i,
    input logic       rc_strobe_i,
    input logic       cp_margin_i,
    input logic       warn_flag_o,
    input logic       sd_flag_o,
    input logic [1:0] ls_mode_o,
    input logic [1:0] hs_mode_o,
    input logic       cp_disable_o
);

    assert_reset_state_R10: assert property (@(posedge clk_i)
        rst_i |=> (!warn_flag_o && !sd_flag_o && ls_mode_o == 2'b00 &&
                   hs_mode_o == 2'b00 && !cp_disable_o));

    assert_warn_needs_cond_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(warn_flag_o) |-> $past(warn_above_i));

    assert_warn_clear_on_strobe_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(warn_flag_o) |-> $past(rc_strobe_i));

    assert_sd_needs_cond_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sd_flag_o) |-> $past(sd_above_i));

    assert_cp_tracks_flag_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        sd_flag_o == cp_disable_o);

    assert_ls_sink_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sd_flag_o |-> ls_mode_o == DRV_SINK);

    assert_ls_normal_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !sd_flag_o |-> (ls_mode_o == DRV_NORMAL && hs_mode_o == DRV_NORMAL));

    assert_hs_legal_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        hs_mode_o != 2'b11);

    assert_margin_ends_sink_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (hs_mode_o == DRV_SINK && !cp_margin_i) |=> hs_mode_o != DRV_SINK);

    assert_sd_clear_on_strobe_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sd_flag_o) |-> $past(rc_strobe_i));

endmodule

bind thermal_fault_ctrl thermal_fault_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .warn_above_i (warn_above_i),
    .sd_above_i   (sd_above_i),
    .rc_strobe_i  (rc_strobe_i),
    .cp_margin_i  (cp_margin_i),
    .warn_flag_o  (warn_flag_o),
    .sd_flag_o    (sd_flag_o),
    .ls_mode_o    (ls_mode_o),
    .hs_mode_o    (hs_mode_o),
    .cp_disable_o (cp_disable_o)
);

// File: tb/sim_thermal_fault_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_fault_ctrl;

    localparam int unsigned FILT_W = 8;
    localparam int unsigned TICKS  = 8;
    localparam int unsigned L      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [FILT_W-1:0] filt_len = FILT_W'(L);
    logic warn_above = 0, warn_below = 0, sd_above = 0, sd_below = 0;
    logic rc = 0, tick = 0, margin = 1;
    logic warn_flag, sd_flag, cp_dis;
    logic [1:0] ls_mode, hs_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    thermal_fault_ctrl #(.FILT_W(FILT_W), .SINK_TICKS(TICKS)) u0 (
        .clk_i(clk), .rst_i(rst), .filt_len_i(filt_len),
        .warn_above_i(warn_above), .warn_below_i(warn_below),
        .sd_above_i(sd_above), .sd_below_i(sd_below),
        .rc_strobe_i(rc), .tick_i(tick), .cp_margin_i(margin),
        .warn_flag_o(warn_flag), .sd_flag_o(sd_flag),
        .ls_mode_o(ls_mode), .hs_mode_o(hs_mode), .cp_disable_o(cp_dis)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic pulse_rc();
        rc = 1; step(1); rc = 0;
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; step(1); tick = 0; step(1);
        end
    endtask

    task automatic chk_drv(input string req, input int ls, input int hs, input int cp);
        chk({req, " ls"}, ls_mode, ls);
        chk({req, " hs"}, hs_mode, hs);
        chk({req, " cp"}, cp_dis, cp);
    endtask

    // shutdown entry: set edge is the (L+2)-th edge
    task automatic raise_sd();
        sd_above = 1; step(L + 1);
        chk("R5 sd not yet", sd_flag, 0);
        step(1);
        chk("R5 sd set", sd_flag, 1);
        chk("R5 cp off", cp_dis, 1);
        sd_above = 0;
    endtask

    task automatic clear_sd();
        sd_below = 1; step(L + 1);
        pulse_rc();
        sd_below = 0;
        chk("R9 sd cleared", sd_flag, 0);
        chk_drv("R9 released", 0, 0, 0);
    endtask

    task automatic t_reset();
        rst = 1; step(2); rst = 0; step(1);
        chk("R10 warn", warn_flag, 0);
        chk("R10 sd", sd_flag, 0);
        chk_drv("R10 drv", 0, 0, 0);
    endtask

    task automatic t_warn_restart_and_set();
        warn_above = 1; step(L);
        warn_above = 0; step(1);
        warn_above = 1; step(L + 1);
        chk("R3 restart", warn_flag, 0);
        step(1);
        chk("R1 warn set", warn_flag, 1);
        chk_drv("R2 no action", 0, 0, 0);
        warn_above = 0;
    endtask

    task automatic t_warn_clear();
        step(3);
        chk("R4 holds alone", warn_flag, 1);
        pulse_rc();
        chk("R4 band reject", warn_flag, 1);
        warn_below = 1; step(L);
        pulse_rc();
        chk("R4 early reject", warn_flag, 1);
        pulse_rc();
        chk("R4 cleared", warn_flag, 0);
        warn_below = 0;
    endtask

    task automatic t_sd_window();
        margin = 1;
        raise_sd();
        chk_drv("R6 R7 entry", 1, 1, 1);
        pulse_tick(TICKS - 1);
        chk("R7 still sinking", hs_mode, 1);
        tick = 1; step(1); tick = 0;
        chk("R7 window over", hs_mode, 2);
        chk("R6 ls held", ls_mode, 1);
        step(5);
        pulse_rc();
        chk_drv("R9 hot reject", 1, 2, 1);
        sd_below = 1; step(L);
        pulse_rc();
        chk("R9 early reject", sd_flag, 1);
        sd_below = 0;
        step(1);
        clear_sd();
    endtask

    task automatic t_sd_margin_mid();
        margin = 1;
        raise_sd();
        pulse_tick(2);
        chk("R8 pre drop", hs_mode, 1);
        margin = 0; step(1);
        chk("R8 margin drop", hs_mode, 2);
        margin = 1; step(1);
        chk("R8 no return", hs_mode, 2);
        clear_sd();
    endtask

    task automatic t_sd_margin_entry();
        margin = 0;
        raise_sd();
        chk_drv("R8 entry low", 1, 2, 1);
        margin = 1;
        clear_sd();
    endtask

    initial begin
        step(1);
        t_reset();
        t_warn_restart_and_set();
        t_warn_clear();
        t_sd_window();
        t_sd_margin_mid();
        t_sd_margin_entry();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule